// File: doc/BRIEF.md
# Linear Sensor Scan Sequencer

This block is the digital switch-control logic of one section of a linear photodiode array. A scan begins when the serial start input is seen high on a rising clock edge. From that edge on, the block selects one pixel per clock onto the shared analog output and enables that output for the length of the scan. It holds the global integrator reset for a fixed window at the start of the scan, and it tells each pixel's sampling switch when it may track its integrator again. The photodiodes, integrators and output amplifier lie outside the block. Only their control timing is modelled, so every switch event can be checked clock by clock.

A separate hold input freezes the sampling capacitor of every pixel on the same clock edge. In normal use it is tied to the start input. A cascade output is high for one clock at the end of the scan. When it drives the start input of a second section, the two sections form one array of twice the length. A start pulse that arrives while a scan is still running is ignored, and it sets a sticky error flag.

Top module: `linescan_seq`

## Requirements
- R1: When `si` is high at a rising edge while the block is idle, `pix_idx` is 1, `pix_sel[0]` is 1 and `aout_en` is 1 after that edge (edge 1 of the scan).
- R2: After edge k of a scan (1 <= k <= N_PIX), `pix_idx` equals k and `pix_sel` is one-hot with only bit k-1 set.
- R3: A rising edge of `hold`, sampled at a clock edge, clears every bit of `pix_track` (0 = frozen, 1 = tracking) and sets `samp_hold` after that edge. This applies both during a scan and while idle.
- R4: `integ_rst` is 1 after edges 1 through RST_CLKS (18) of a scan and returns to 0 after edge RST_CLKS+1.
- R5: Pixels 1 to RST_CLKS return to tracking after edge RST_CLKS+1, and `samp_hold` falls on that edge.
- R6: Pixel k, for k > RST_CLKS, returns to tracking after edge k+1. This includes the last pixel at edge N_PIX+1, and a pixel read after a mid-scan hold.
- R7: `so` is 1 only after edge N_PIX and is 0 again after edge N_PIX+1.
- R8: If no new start arrives, after edge N_PIX+1 the outputs `aout_en`, `pix_idx` and `pix_sel` are all 0.
- R9: An `si` pulse at edges 2 to N_PIX does not restart the scan, the index, or the reset window, and it sets `proto_err`. A full scan without such a pulse leaves `proto_err` at 0, and the flag stays set until reset.
- R10: After synchronous reset: `aout_en`, `pix_idx`, `pix_sel`, `so`, `integ_rst`, `samp_hold` and `proto_err` are 0, and every `pix_track` bit is 1.
- R11: With two sections chained (`so` of the first to `si` of the second, both holds on the first start), the second section selects its pixel 1 at edge N_PIX+1, raises `so` at edge 2*N_PIX, and has `so` and `aout_en` at 0 after edge 2*N_PIX+1.
- R12: A start at edge N_PIX+1 is legal. It selects pixel 1, keeps `aout_en` at 1, clears `so`, restarts `integ_rst`, and leaves `proto_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Serial start of scan |
| hold | input | 1 | Freeze request; its rising edge stops all sampling switches |
| pix_sel | output | N_PIX | One-hot pixel selected onto the output |
| pix_idx | output | $clog2(N_PIX+1) | Selected pixel number, 1-based; 0 when idle |
| aout_en | output | 1 | Analog output driven (0 = high impedance) |
| integ_rst | output | 1 | Global integrator reset |
| samp_hold | output | 1 | All sampling switches frozen since the last hold |
| pix_track | output | N_PIX | Per-pixel sampling switch: 1 tracking, 0 frozen |
| so | output | 1 | Cascade output, one clock at scan end |
| proto_err | output | 1 | Sticky flag for a start pulse during a scan |

## Verification
On every cycle, the assertions check the following:
- The select vector is one-hot or empty, and the index steps by exactly one.
- A start is followed by pixel 1 being driven.
- The reset window ends exactly when pixel RST_CLKS+1 is selected.
- The cascade output rises only on the last pixel.
- A hold edge freezes every pixel.
- The error flag never clears on its own.

Other behaviour is shown only by the bench's scenarios. These are the exact edge numbers at which individual pixels resume tracking, the restart on the closing edge, the ignored mid-scan pulse, and the 2*N_PIX+1 clock length of a two-section cascade.

// File: rtl/linescan_pkg.sv
package linescan_pkg;
  localparam int unsigned DEF_PIXELS   = 384;
  localparam int unsigned DEF_RST_CLKS = 18;

  function automatic int unsigned idx_width(input int unsigned pixels);
    return $clog2(pixels + 1);
  endfunction
endpackage

// File: rtl/linescan_pos.sv
module linescan_pos #(
  parameter int unsigned N_PIX = linescan_pkg::DEF_PIXELS,
  localparam int unsigned IDXW = linescan_pkg::idx_width(N_PIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             si,
  output logic             start,
  output logic             si_bad,
  output logic [N_PIX-1:0] sel,
  output logic [IDXW-1:0]  idx,
  output logic             aout_en,
  output logic             so
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N_PIX);
  localparam logic [IDXW-1:0] PENULT = IDXW'(N_PIX - 1);

  logic can_start;
  assign can_start = (idx == '0) || (idx == LAST);
  assign start     = si && can_start;
  assign si_bad    = si && !can_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      idx     <= '0;
      aout_en <= 1'b0;
      so      <= 1'b0;
    end else if (start) begin
      sel     <= {{(N_PIX-1){1'b0}}, 1'b1};
      idx     <= IDXW'(1);
      aout_en <= 1'b1;
      so      <= 1'b0;
    end else begin
      sel     <= sel << 1;
      if (idx == LAST)       idx <= '0;
      else if (idx != '0)    idx <= idx + IDXW'(1);
      aout_en <= (idx != '0) && (idx != LAST);
      so      <= (idx == PENULT);
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (idx == IDXW'(1)) && sel[0] && aout_en);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (idx != '0 && idx != LAST && !start) |=> idx == $past(idx) + IDXW'(1));
  assert_so_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(so) |-> (idx == LAST) && sel[N_PIX-1]);
  assert_end_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (idx == LAST && !start) |=> !aout_en && (sel == '0) && !so);
endmodule

// File: rtl/linescan_rstwin.sv
module linescan_rstwin #(
  parameter int unsigned RST_CLKS = linescan_pkg::DEF_RST_CLKS,
  localparam int unsigned CW = $clog2(RST_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic integ_rst
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      integ_rst <= 1'b0;
    end else if (start) begin
      cnt       <= CW'(1);
      integ_rst <= 1'b1;
    end else if (integ_rst) begin
      if (cnt == CW'(RST_CLKS)) begin
        cnt       <= '0;
        integ_rst <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_win_open_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> integ_rst);
endmodule

// File: rtl/linescan_track.sv
module linescan_track #(
  parameter int unsigned N_PIX    = linescan_pkg::DEF_PIXELS,
  parameter int unsigned RST_CLKS = linescan_pkg::DEF_RST_CLKS,
  localparam int unsigned NREL = N_PIX - RST_CLKS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [NREL-1:0]  sel_hi,
  output logic [N_PIX-1:0] track,
  output logic             samp_hold
);
  logic             hold_q;
  logic             hold_rise;
  logic [N_PIX-1:0] release_v;

  assign hold_rise = hold && !hold_q;

  for (genvar g = 0; g < N_PIX; g++) begin : g_rel
    if (g + 1 <= RST_CLKS) begin : g_early
      assign release_v[g] = sel_hi[0];
    end else begin : g_late
      assign release_v[g] = sel_hi[g + 1 - RST_CLKS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      track     <= '1;
      samp_hold <= 1'b0;
    end else begin
      hold_q <= hold;
      if (hold_rise) begin
        track     <= '0;
        samp_hold <= 1'b1;
      end else begin
        track <= track | release_v;
        if (|release_v) samp_hold <= 1'b0;
      end
    end
  end

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    hold_rise |=> (track == '0) && samp_hold);
  assert_samp_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(samp_hold) && !$past(rst)) |-> (track != '0));
endmodule

// File: rtl/linescan_seq.sv
module linescan_seq #(
  parameter int unsigned N_PIX    = linescan_pkg::DEF_PIXELS,
  parameter int unsigned RST_CLKS = linescan_pkg::DEF_RST_CLKS,
  localparam int unsigned IDXW = linescan_pkg::idx_width(N_PIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             si,
  input  logic             hold,
  output logic [N_PIX-1:0] pix_sel,
  output logic [IDXW-1:0]  pix_idx,
  output logic             aout_en,
  output logic             integ_rst,
  output logic             samp_hold,
  output logic [N_PIX-1:0] pix_track,
  output logic             so,
  output logic             proto_err
);
  logic start;
  logic si_bad;

  linescan_pos #(.N_PIX(N_PIX)) u_pos (
    .clk(clk), .rst(rst), .si(si), .start(start), .si_bad(si_bad),
    .sel(pix_sel), .idx(pix_idx), .aout_en(aout_en), .so(so)
  );

  linescan_rstwin #(.RST_CLKS(RST_CLKS)) u_rstwin (
    .clk(clk), .rst(rst), .start(start), .integ_rst(integ_rst)
  );

  linescan_track #(.N_PIX(N_PIX), .RST_CLKS(RST_CLKS)) u_track (
    .clk(clk), .rst(rst), .hold(hold),
    .sel_hi(pix_sel[N_PIX-1:RST_CLKS-1]),
    .track(pix_track), .samp_hold(samp_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else if (si_bad) proto_err <= 1'b1;
  end

  assert_rst_release_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(integ_rst) && !$past(rst)) |-> pix_idx == IDXW'(RST_CLKS + 1));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(proto_err) && !$past(rst)) |-> proto_err);
  assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
    (si && aout_en && pix_idx != IDXW'(N_PIX)) |=> proto_err);
  assert_en_idx_R8: assert property (@(posedge clk) disable iff (rst)
    aout_en == (pix_idx != '0));
endmodule

// File: tb/linescan_seq_test.sv
module linescan_seq_test;
  localparam int N = 384;
  localparam int R = 18;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic si = 1'b0;
  logic hold = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] sel1, trk1, sel2, trk2;
  logic [IW-1:0] idx1, idx2;
  logic en1, ir1, sh1, so1, er1, en2, ir2, sh2, so2, er2;

  linescan_seq #(.N_PIX(N), .RST_CLKS(R)) uut (
    .clk(clk), .rst(rst), .si(si), .hold(hold), .pix_sel(sel1), .pix_idx(idx1),
    .aout_en(en1), .integ_rst(ir1), .samp_hold(sh1), .pix_track(trk1),
    .so(so1), .proto_err(er1));

  linescan_seq #(.N_PIX(N), .RST_CLKS(R)) sec2 (
    .clk(clk), .rst(rst), .si(so1), .hold(si), .pix_sel(sel2), .pix_idx(idx2),
    .aout_en(en2), .integ_rst(ir2), .samp_hold(sh2), .pix_track(trk2),
    .so(so2), .proto_err(er2));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int TN = 10;
  localparam int T_EDGE [TN] = '{1, 2, 17, 18, 19, 20, 200, 383, 384, 385};
  localparam int T_IDX  [TN] = '{1, 2, 17, 18, 19, 20, 200, 383, 384, 0};
  localparam int T_SO   [TN] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int T_EN   [TN] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int T_RST  [TN] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic h);
    @(negedge clk);
    si = s;
    hold = h;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; si = 1'b0; hold = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R10 reset state
    chk("R10", "aout_en", int'(en1), 0);
    chk("R10", "pix_idx", int'(idx1), 0);
    chk("R10", "pix_sel zero", int'(sel1 == '0), 1);
    chk("R10", "so", int'(so1), 0);
    chk("R10", "integ_rst", int'(ir1), 0);
    chk("R10", "samp_hold", int'(sh1), 0);
    chk("R10", "proto_err", int'(er1), 0);
    chk("R10", "track all ones", int'(trk1 == '1), 1);

    // Table walk: one scan plus the cascade, hold tied to start
    for (int e = 1; e <= 2 * N + 1; e++) begin
      step(e == 1, e == 1);
      for (int t = 0; t < TN; t++) begin
        if (T_EDGE[t] == e) begin
          chk("R2", $sformatf("idx edge %0d", e), int'(idx1), T_IDX[t]);
          chk("R7", $sformatf("so edge %0d", e), int'(so1), T_SO[t]);
          chk("R8", $sformatf("aout_en edge %0d", e), int'(en1), T_EN[t]);
          chk("R4", $sformatf("integ_rst edge %0d", e), int'(ir1), T_RST[t]);
        end
      end
      if (e == 1) begin
        chk("R1", "sel[0] at start", int'(sel1[0]), 1);
        chk("R3", "track frozen at start", int'(trk1 == '0), 1);
        chk("R3", "samp_hold at start", int'(sh1), 1);
      end
      if (e == 100) chk("R2", "onehot bit 99", int'(sel1 == (N'(1) << 99)), 1);
      if (e == R) chk("R5", "pixel1 frozen edge 18", int'(trk1[0]), 0);
      if (e == R + 1) begin
        chk("R5", "pixel1 tracks edge 19", int'(trk1[0]), 1);
        chk("R5", "pixel18 tracks edge 19", int'(trk1[R-1]), 1);
        chk("R5", "samp_hold clear edge 19", int'(sh1), 0);
        chk("R6", "pixel19 frozen edge 19", int'(trk1[R]), 0);
      end
      if (e == R + 2) chk("R6", "pixel19 tracks edge 20", int'(trk1[R]), 1);
      if (e == N) chk("R6", "last pixel frozen edge N", int'(trk1[N-1]), 0);
      if (e == N + 1) begin
        chk("R6", "last pixel tracks edge N+1", int'(trk1[N-1]), 1);
        chk("R8", "sel empty edge N+1", int'(sel1 == '0), 1);
        chk("R11", "sec2 pixel1 edge N+1", int'(idx2), 1);
        chk("R11", "sec2 aout_en edge N+1", int'(en2), 1);
      end
      if (e == 2 * N) chk("R11", "sec2 so edge 2N", int'(so2), 1);
      if (e == 2 * N + 1) begin
        chk("R11", "sec2 so edge 2N+1", int'(so2), 0);
        chk("R11", "sec2 aout_en edge 2N+1", int'(en2), 0);
      end
    end
    chk("R9", "no error after clean scan", int'(er1), 0);

    // R12 restart on the closing edge
    do_reset();
    for (int e = 1; e <= N; e++) step(e == 1, e == 1);
    step(1'b1, 1'b1);
    chk("R12", "restart idx", int'(idx1), 1);
    chk("R12", "restart aout_en", int'(en1), 1);
    chk("R12", "restart so", int'(so1), 0);
    chk("R12", "restart integ_rst", int'(ir1), 1);
    chk("R12", "restart proto_err", int'(er1), 0);

    // R9 start pulse during a scan is ignored
    do_reset();
    for (int e = 1; e <= 4; e++) step(e == 1, e == 1);
    step(1'b1, 1'b0);
    chk("R9", "idx after bad si", int'(idx1), 5);
    chk("R9", "proto_err set", int'(er1), 1);
    for (int e = 6; e <= R + 1; e++) step(1'b0, 1'b0);
    chk("R9", "reset window not restarted", int'(ir1), 0);
    chk("R9", "idx keeps counting", int'(idx1), R + 1);
    for (int e = R + 2; e <= N + 3; e++) step(1'b0, 1'b0);
    chk("R9", "proto_err sticky", int'(er1), 1);

    // R3 / R6 hold in the middle of a scan
    do_reset();
    for (int e = 1; e <= 29; e++) step(e == 1, e == 1);
    step(1'b0, 1'b1);
    chk("R3", "mid-scan hold freezes all", int'(trk1 == '0), 1);
    chk("R3", "mid-scan samp_hold", int'(sh1), 1);
    step(1'b0, 1'b1);
    chk("R6", "pixel30 tracks edge 31", int'(trk1[29]), 1);
    chk("R6", "pixel1 stays frozen", int'(trk1[0]), 0);
    chk("R5", "samp_hold clears on release", int'(sh1), 0);

    // R3 hold while idle
    do_reset();
    step(1'b0, 1'b1);
    chk("R3", "idle hold freezes", int'(trk1 == '0), 1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R3", "idle samp_hold stays", int'(sh1), 1);
    chk("R8", "idle aout_en", int'(en1), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule